// File: doc/BRIEF.md
# Asynchronous Memory Read Timing Controller

This block runs a single read cycle on an external asynchronous parallel memory. Four cycle counts shape the cycle: when chip select is released, when output enable is released, the cycle in which the data bus is captured (the access point), and the cycle in which the whole read ends. All four are measured from the first active cycle. A request is accepted only while the block is idle and only when the configuration leaves one cycle of data hold after the access point. Otherwise the request is refused with an error pulse.

The memory can stretch a read with its WAIT pin. The pin first passes through a two-stage synchronizer, so its level in cycle k becomes visible in cycle k+2. The controller looks at the synchronized level only when the cycle counter reaches the access point. If it is asserted there, the counter stops and stays stopped until the synchronized level clears. The data bus is captured at the end of the first cycle at the access point in which WAIT is seen clear. Polarity and an enable select whether WAIT is active-high, active-low or ignored.

Top module: `async_read_timer`

## Requirements
- R1: After reset, mem_cs_n and mem_oe_n are 1; busy, read_done and cfg_error are 0; read_data is 0.
- R2: A start seen at a clock edge while idle, with a valid configuration, makes busy 1 in the next cycle (counter value 0), with mem_cs_n and mem_oe_n both 0.
- R3: While busy, mem_cs_n is 0 exactly when the counter is below cs_off_time, and mem_oe_n is 0 exactly when the counter is below oe_off_time. Both are 1 while idle.
- R4: Without a stall, mem_data is captured into read_data at the clock edge that ends the cycle in which the counter equals access_time.
- R5: read_done is 1 for exactly one cycle, the cycle in which the counter equals cycle_time. busy is 0 in the following cycle.
- R6: The level of wait_pin in cycle k is seen by the controller in cycle k+2. A WAIT asserted in cycle access_time-2 makes the counter stop at access_time.
- R7: While the synchronized WAIT is asserted at the access point, the counter holds and nothing is captured. If raw WAIT is asserted continuously from cycle access_time-2 or earlier up to cycle b, capture and counting resume at the end of cycle b+3, which delays read_done by b+3-access_time cycles.
- R8: WAIT is ignored outside the access point. A WAIT that ends before cycle access_time-2, or that begins after it, does not change any timing.
- R9: With wait_enable=1, wait_active_high=1 means a high pin asserts WAIT and wait_active_high=0 means a low pin asserts WAIT. With wait_enable=0, the pin has no effect.
- R10: If cs_off_time, oe_off_time or cycle_time is not greater than access_time, a start makes cfg_error 1 for one cycle. No read begins: busy stays 0, mem_cs_n stays 1 and read_data is unchanged.
- R11: start has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one read cycle |
| cs_off_time | input | 8 | Counter value at which chip select is released |
| oe_off_time | input | 8 | Counter value at which output enable is released |
| access_time | input | 8 | Counter value of the data capture point |
| cycle_time | input | 8 | Counter value of the last cycle of the read |
| wait_enable | input | 1 | 1 = WAIT is monitored |
| wait_active_high | input | 1 | 1 = high pin asserts WAIT, 0 = low pin asserts WAIT |
| wait_pin | input | 1 | Raw WAIT from the memory |
| mem_data | input | DATA_W (16) | Memory data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | Read cycle in progress |
| read_data | output | DATA_W (16) | Captured word |
| read_done | output | 1 | One-cycle end-of-read strobe |
| cfg_error | output | 1 | One-cycle pulse: start refused because of the timing configuration |

## Verification
The two events that can fall in the same cycle are the counter arriving at the access point and the synchronized WAIT clearing. The bench provokes this by ending raw WAIT exactly in cycle access_time-2, which must give a one-cycle stall. It also starts WAIT one cycle later, which must give no stall at all. In each case the bench judges the outcome from the cycle in which read_done appears, from the per-cycle chip-select and output-enable levels, and from which per-cycle data word ends up in read_data.

// File: rtl/async_read_pkg.sv
package async_read_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] cs_off;
        logic [CNT_W-1:0] oe_off;
        logic [CNT_W-1:0] access;
        logic [CNT_W-1:0] cycle;
    } timing_cfg_t;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic freeze;
        logic sample;
        logic at_end;
    } strobe_t;

    // every release point must leave one hold cycle after the access point
    function automatic logic timing_ok(timing_cfg_t c);
        return (c.cs_off > c.access) && (c.oe_off > c.access) && (c.cycle > c.access);
    endfunction

endpackage

// File: rtl/wait_sync.sv
module wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic enable,
    input  logic active_high,
    output logic wait_seen
);
    logic [STAGES-1:0] pipe;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= 1'b0;
                    else     pipe[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= 1'b0;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign wait_seen = enable && (pipe[STAGES-1] == active_high);

endmodule

// File: rtl/cycle_counter.sv
module cycle_counter
    import async_read_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (clear)   count <= '0;
        else if (advance) count <= count + 1'b1;
    end

    // R7: a frozen counter keeps its value
    assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!clear && !advance) |=> (count == $past(count)));

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import async_read_pkg::*;
(
    input  logic             active,
    input  logic [CNT_W-1:0] count,
    input  timing_cfg_t      cfg,
    input  logic             wait_seen,
    output strobe_t          strb
);
    logic at_access;

    always_comb begin
        at_access   = active && (count == cfg.access);
        strb.cs_n   = !(active && (count < cfg.cs_off));
        strb.oe_n   = !(active && (count < cfg.oe_off));
        strb.freeze = at_access && wait_seen;
        strb.sample = at_access && !wait_seen;
        strb.at_end = active && (count == cfg.cycle);
    end

endmodule

// File: rtl/async_read_timer.sv
module async_read_timer
    import async_read_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  cs_off_time,
    input  logic [CNT_W-1:0]  oe_off_time,
    input  logic [CNT_W-1:0]  access_time,
    input  logic [CNT_W-1:0]  cycle_time,
    input  logic              wait_enable,
    input  logic              wait_active_high,
    input  logic              wait_pin,
    input  logic [DATA_W-1:0] mem_data,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              busy,
    output logic [DATA_W-1:0] read_data,
    output logic              read_done,
    output logic              cfg_error
);
    rd_state_e        state;
    timing_cfg_t      cfg;
    strobe_t          strb;
    logic [CNT_W-1:0] count;
    logic             wait_seen;
    logic             active;
    logic             launch;
    logic             refuse;
    logic             advance;

    assign cfg.cs_off = cs_off_time;
    assign cfg.oe_off = oe_off_time;
    assign cfg.access = access_time;
    assign cfg.cycle  = cycle_time;

    assign active  = (state == ST_ACTIVE);
    assign launch  = (state == ST_IDLE) && start && timing_ok(cfg);
    assign refuse  = (state == ST_IDLE) && start && !timing_ok(cfg);
    assign advance = active && !strb.freeze && !strb.at_end;

    wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .pin         (wait_pin),
        .enable      (wait_enable),
        .active_high (wait_active_high),
        .wait_seen   (wait_seen)
    );

    cycle_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (launch),
        .advance (advance),
        .count   (count)
    );

    strobe_gen u_strb (
        .active    (active),
        .count     (count),
        .cfg       (cfg),
        .wait_seen (wait_seen),
        .strb      (strb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg_error <= 1'b0;
        end else begin
            cfg_error <= refuse;
            if (launch)
                state <= ST_ACTIVE;
            else if (strb.at_end)
                state <= ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              read_data <= '0;
        else if (strb.sample) read_data <= mem_data;
    end

    assign mem_cs_n  = strb.cs_n;
    assign mem_oe_n  = strb.oe_n;
    assign busy      = active;
    assign read_done = strb.at_end;

    // R5: the end strobe never lasts two cycles
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        read_done |=> !read_done);

    // R3: chip select only during a read
    assert_cs_in_read_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> busy);

    // R4: capture happens while the memory is still driving
    assert_capture_driven_R4: assert property (@(posedge clk) disable iff (rst)
        strb.sample |-> (!mem_oe_n && !mem_cs_n));

    // R10: a refused request leaves the bus idle
    assert_refused_idle_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> (!busy && mem_cs_n && mem_oe_n));

    // R5: the read ends with the controller idle on the next cycle
    assert_end_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
        read_done |=> !busy);

endmodule

// File: tb/tb_async_read_timer.sv
module tb_async_read_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [7:0]    cs_off_time, oe_off_time, access_time, cycle_time;
    logic          wait_enable, wait_active_high, wait_pin;
    logic [DW-1:0] mem_data;
    logic          mem_cs_n, mem_oe_n, busy, read_done, cfg_error;
    logic [DW-1:0] read_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_read_timer dut (
        .clk(clk), .rst(rst), .start(start),
        .cs_off_time(cs_off_time), .oe_off_time(oe_off_time),
        .access_time(access_time), .cycle_time(cycle_time),
        .wait_enable(wait_enable), .wait_active_high(wait_active_high),
        .wait_pin(wait_pin), .mem_data(mem_data),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .busy(busy),
        .read_data(read_data), .read_done(read_done), .cfg_error(cfg_error)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] word_at(input logic [DW-1:0] base, input int k);
        return base ^ DW'(k * 16'h3b1 + 7);
    endfunction

    function automatic int stall_len(input int acc, input bit en, input int wa, input int wb);
        if (en && wa >= 0 && wa <= acc - 2 && wb >= acc - 2) return wb + 3 - acc;
        return 0;
    endfunction

    function automatic int exp_count(input int k, input int acc, input int stall);
        if (k <= acc) return k;
        if (k <= acc + stall) return acc;
        return k - stall;
    endfunction

    task automatic run_read(input int cs, input int oe, input int acc, input int cyc,
                            input bit en, input bit pol, input int wa, input int wb,
                            input int poke, input string tag);
        int stall, dn, ce;
        bit bad;
        logic [DW-1:0] base, prev;
        cs_off_time = 8'(cs); oe_off_time = 8'(oe);
        access_time = 8'(acc); cycle_time = 8'(cyc);
        wait_enable = en; wait_active_high = pol; wait_pin = ~pol;
        start = 1'b0;
        repeat (2) @(negedge clk);
        bad   = (cs < acc + 1) || (oe < acc + 1) || (cyc < acc + 1);
        stall = stall_len(acc, en, wa, wb);
        base  = DW'($urandom);
        prev  = read_data;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            check(cfg_error == 1'b1, "R10 error pulse", int'(cfg_error), 1);
            check(mem_cs_n && mem_oe_n && !busy, "R10 no read", int'(busy), 0);
            @(negedge clk);
            check(cfg_error == 1'b0 && !busy, "R10 single pulse", int'(cfg_error), 0);
            check(read_data == prev, "R10 data unchanged", int'(read_data), int'(prev));
            return;
        end
        check(cfg_error == 1'b0, "R10 valid config no error", int'(cfg_error), 0);
        dn = cyc + stall;
        for (int k = 0; k <= dn; k++) begin
            mem_data = word_at(base, k);
            wait_pin = (k >= wa && k <= wb) ? pol : ~pol;
            start    = (k == poke);
            ce = exp_count(k, acc, stall);
            check(busy == 1'b1, "R2 busy", int'(busy), 1);
            check(mem_cs_n == !(ce < cs), "R3 cs_n", int'(mem_cs_n), int'(!(ce < cs)));
            check(mem_oe_n == !(ce < oe), "R3 oe_n", int'(mem_oe_n), int'(!(ce < oe)));
            check(read_done == (k == dn), {tag, " done cycle"}, int'(read_done), int'(k == dn));
            @(negedge clk);
        end
        start = 1'b0;
        wait_pin = ~pol;
        check(!busy && !read_done && mem_cs_n && mem_oe_n, "R5 idle after done", int'(busy), 0);
        check(read_data == word_at(base, acc + stall), {tag, " captured word"},
              int'(read_data), int'(word_at(base, acc + stall)));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; wait_pin = 1'b0; wait_enable = 1'b0;
        wait_active_high = 1'b1; mem_data = '0;
        cs_off_time = 8'd1; oe_off_time = 8'd1; access_time = 8'd0; cycle_time = 8'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(mem_cs_n && mem_oe_n && !busy && !read_done && !cfg_error, "R1 idle outputs",
              int'({mem_cs_n, mem_oe_n, busy, read_done, cfg_error}), 5'b11000);
        check(read_data == '0, "R1 read_data", int'(read_data), 0);

        // R2/R4 plain read
        run_read(4, 5, 3, 7, 1'b0, 1'b1, -9, -9, -1, "R4");
        // R6 WAIT asserted well before access point, active-high
        run_read(8, 8, 6, 9, 1'b1, 1'b1, 2, 6, -1, "R6");
        // R7 WAIT ends exactly at cycle access-2: one-cycle stall
        run_read(6, 7, 5, 8, 1'b1, 1'b1, 1, 3, -1, "R7");
        // R8 WAIT starting one cycle too late is ignored
        run_read(6, 7, 5, 8, 1'b1, 1'b1, 4, 9, -1, "R8");
        // R8 WAIT ending before the window is ignored
        run_read(7, 7, 6, 8, 1'b1, 1'b1, 0, 3, -1, "R8");
        // R9 active-low polarity stalls
        run_read(5, 6, 4, 7, 1'b1, 1'b0, 0, 5, -1, "R9");
        // R9 monitoring disabled
        run_read(5, 6, 4, 7, 1'b0, 1'b1, 0, 5, -1, "R9");
        // R10 each bad field
        run_read(3, 6, 3, 7, 1'b0, 1'b1, -9, -9, -1, "R10");
        run_read(6, 3, 3, 7, 1'b0, 1'b1, -9, -9, -1, "R10");
        run_read(6, 6, 3, 3, 1'b0, 1'b1, -9, -9, -1, "R10");
        // R11 start while busy
        run_read(4, 4, 3, 9, 1'b1, 1'b1, 0, 2, 5, "R11");
        // R3 off times beyond the cycle end; minimal access time
        run_read(12, 15, 2, 5, 1'b0, 1'b1, -9, -9, -1, "R3");
        run_read(1, 1, 0, 1, 1'b1, 1'b1, 0, 4, -1, "R8");

        for (int n = 0; n < 200; n++) begin
            int acc, cs, oe, cyc, wa, wb;
            acc = $urandom_range(0, 12);
            cs  = acc + 1 + $urandom_range(0, 5);
            oe  = acc + 1 + $urandom_range(0, 5);
            cyc = acc + 1 + $urandom_range(0, 5);
            if ($urandom_range(0, 7) == 0) begin
                case ($urandom_range(0, 2))
                    0: cs  = $urandom_range(0, acc);
                    1: oe  = $urandom_range(0, acc);
                    default: cyc = $urandom_range(0, acc);
                endcase
            end
            wa = $urandom_range(0, acc + 3);
            wb = wa + $urandom_range(0, 6);
            run_read(cs, oe, acc, cyc, 1'($urandom), 1'($urandom), wa, wb,
                     $urandom_range(0, 20), "R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule